// File: doc/BRIEF.md
# Bit-Field Peripheral Register Access Unit

This unit executes the two peripheral-access instructions of a small coprocessor. A sequencer presents a 32-bit instruction word together with a one-cycle `start` pulse. The unit decodes a bank select, a word address and a bit range `[hi:lo]` from the word. It then either reads that range into general register R0, or overwrites the range with an 8-bit literal and leaves the rest of the register untouched.

The unit reaches the registers over a simple 32-bit request/response bus with one select line per bank. A write always runs as a read of the target word, then a merge under a mask built from `lo` and `hi`, then a write of the merged word. When the operation finishes, `done` pulses for one cycle. If a read produced a result, `r0_we` pulses in the same cycle. An instruction with an impossible bank or an inverted bit range makes no bus access and finishes at once with `err` set.

Top module: `bitfield_reg_unit`

## Requirements
- R1: The instruction word is decoded as follows: address in bits 7:0, bank select in bits 9:8, literal in bits 17:10, low bit `lo` in bits 22:18, high bit `hi` in bits 27:23, opcode in bits 31:28. Opcode 1 is a field write and opcode 2 is a field read.
- R2: Bank select values map to one-hot select lines. Value 0 drives `bus_sel[0]` (control bank), value 1 drives `bus_sel[1]` (IO bank) and value 2 drives `bus_sel[2]` (sensor bank). Exactly one line is high whenever `bus_req` is high.
- R3: A write sets bits `[hi:lo]` of the target word to the literal, zero-extended, so field bits more than 8 above `lo` become 0. All other bits of the word keep their old value.
- R4: A read puts bits `[hi:lo]` of the target word, shifted down by `lo` and zero-extended, into the 16-bit `r0_data`. Only the low 16 field bits are kept. `r0_we` is high only in the `done` cycle of a legal read.
- R5: A write first holds a read request (`bus_we`=0) until `bus_rvalid`, then holds a write request (`bus_we`=1) until `bus_wack`. The address and request stay stable while waiting for a response.
- R6: `done` is a one-cycle pulse. It comes in the cycle after `bus_wack` for writes and in the cycle after `bus_rvalid` for reads.
- R7: Bank select 3 makes no bus access. `done` and `err` go high together in the cycle after `start`.
- R8: An instruction with `hi` < `lo` makes no bus access. `done` and `err` go high together in the cycle after `start`.
- R9: An opcode other than 1 or 2 is ignored: no bus access and no `done`.
- R10: `start` is ignored while an operation is in progress.
- R11: While reset is asserted (`rst_n` low) and after it is released, `done`, `err`, `bus_req` and `r0_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid pulse |
| insn | input | 32 | Instruction word |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Illegal bank or inverted range, valid with done |
| r0_we | output | 1 | Write enable for R0 |
| r0_data | output | 16 | Extracted field for R0 |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_sel | output | 3 | One-hot bank select |
| bus_addr | output | 8 | Word address within bank |
| bus_wdata | output | 32 | Merged write data |
| bus_rdata | input | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | input | 1 | Read response |
| bus_wack | input | 1 | Write accepted |

## Verification
The main tests cover both operations with several field shapes:
- a mid-word byte over an all-ones word, which shows that surrounding bits survive;
- a two-bit field near the top;
- a full 32-bit field, which shows the bits above the literal are cleared;
- a single top bit, which shows the literal is clipped to the field width;
- reads of a byte at the top, of a full word (clipped to 16 bits) and of a single bit.

Each operation lands in a different bank, and the bus response latency varies from 0 to 2 extra cycles, so each bank mapping and the waiting behaviour are exercised. Directed tests cover the two illegal encodings, unknown opcodes and a second `start` that arrives mid-operation. For each of these the tests check the bus access count and the target memory.

// File: rtl/bitfield_reg_unit.sv
module bitfield_reg_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] insn,
  output logic        done,
  output logic        err,
  output logic        r0_we,
  output logic [15:0] r0_data,
  output logic        bus_req,
  output logic        bus_we,
  output logic [2:0]  bus_sel,
  output logic [7:0]  bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_rvalid,
  input  logic        bus_wack
);
  localparam logic [3:0] OP_WR = 4'd1;
  localparam logic [3:0] OP_RD = 4'd2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} st_t;
  st_t st;

  logic [31:0] iq, rq;
  logic        eq;

  wire [3:0] op_in    = insn[31:28];
  wire       legal_op = (op_in == OP_WR) || (op_in == OP_RD);
  wire       bad_in   = (insn[9:8] == 2'd3) || (insn[27:23] < insn[22:18]);

  wire [1:0] sel    = iq[9:8];
  wire [7:0] lit    = iq[17:10];
  wire [4:0] lo     = iq[22:18];
  wire [4:0] hi     = iq[27:23];
  wire       is_rd  = (iq[31:28] == OP_RD);

  wire [31:0] mask  = (32'hFFFF_FFFF >> (5'd31 - hi)) & (32'hFFFF_FFFF << lo);
  wire [31:0] field = ({24'd0, lit} << lo) & mask;
  wire [31:0] ext   = (rq & mask) >> lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      iq <= '0;
      rq <= '0;
      eq <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start && legal_op) begin
          iq <= insn;
          eq <= bad_in;
          st <= bad_in ? S_FIN : S_RD;
        end
        S_RD: if (bus_rvalid) begin
          rq <= bus_rdata;
          st <= is_rd ? S_FIN : S_WR;
        end
        S_WR: if (bus_wack) st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_req   = (st == S_RD) || (st == S_WR);
  assign bus_we    = (st == S_WR);
  assign bus_sel   = bus_req ? (3'd1 << sel) : 3'd0;
  assign bus_addr  = iq[7:0];
  assign bus_wdata = (rq & ~mask) | field;
  assign done      = (st == S_FIN);
  assign err       = done && eq;
  assign r0_we     = done && is_rd && !eq;
  assign r0_data   = ext[15:0];
endmodule

module bitfield_reg_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] insn,
  input logic        done,
  input logic        err,
  input logic        r0_we,
  input logic        bus_req,
  input logic        bus_we,
  input logic [2:0]  bus_sel,
  input logic [7:0]  bus_addr,
  input logic        bus_rvalid,
  input logic        bus_wack,
  input logic        idle
);
  wire legal = (insn[31:28] == 4'd1) || (insn[31:28] == 4'd2);

  p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> $countones(bus_sel) == 1);

  p_r0_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    r0_we |-> done && !err);

  p_write_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we) |-> $past(bus_rvalid));

  p_hold_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rvalid && !bus_wack) |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_bad_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && legal && insn[9:8] == 2'd3) |=> done && err && !bus_req);

  p_inverted_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && legal && insn[27:23] < insn[22:18]) |=> done && err && !bus_req);

  p_ignored_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && !legal) |=> !bus_req && !done);
endmodule

bind bitfield_reg_unit bitfield_reg_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .done(done), .err(err),
  .r0_we(r0_we), .bus_req(bus_req), .bus_we(bus_we), .bus_sel(bus_sel),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .bus_wack(bus_wack),
  .idle(st == S_IDLE)
);

// File: tb/bitfield_reg_unit_test.sv
module bitfield_reg_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {op[3:0], sel[1:0], addr[7:0], lit[7:0], lo[4:0], hi[4:0], init[31:0]}
  localparam logic [63:0] VEC [NV] = '{
    {4'd1, 2'd0, 8'h10, 8'hA5, 5'd4,  5'd11, 32'hFFFF_FFFF},
    {4'd1, 2'd1, 8'h22, 8'h01, 5'd26, 5'd27, 32'h0000_0000},
    {4'd1, 2'd2, 8'hFF, 8'h3C, 5'd0,  5'd31, 32'hDEAD_BEEF},
    {4'd1, 2'd0, 8'h00, 8'hFF, 5'd31, 5'd31, 32'h0000_0000},
    {4'd2, 2'd1, 8'h22, 8'h00, 5'd24, 5'd31, 32'h1234_5678},
    {4'd2, 2'd2, 8'h05, 8'h00, 5'd0,  5'd31, 32'hCAFE_BABE},
    {4'd2, 2'd0, 8'h80, 8'h00, 5'd7,  5'd7,  32'h0000_0080},
    {4'd1, 2'd2, 8'h05, 8'h00, 5'd8,  5'd15, 32'hFFFF_FFFF}
  };

  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] insn = '0;
  logic        done, err, r0_we, bus_req, bus_we;
  logic [15:0] r0_data;
  logic [2:0]  bus_sel;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid, bus_wack;

  int nchk = 0, nfail = 0, acc = 0, lat = 0, cnt = 0;
  logic [31:0] mem [3][256];
  logic        pl_en = 0;
  logic [1:0]  pl_bank = 0;
  logic [7:0]  pl_addr = 0;
  logic [31:0] pl_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfield_reg_unit uut (.*);

  wire [1:0] bidx = bus_sel[1] ? 2'd1 : (bus_sel[2] ? 2'd2 : 2'd0);

  always @(posedge clk) begin
    if (pl_en) mem[pl_bank][pl_addr] <= pl_data;
    if (!rst_n) begin
      bus_rvalid <= 0; bus_wack <= 0; bus_rdata <= '0; cnt <= 0;
    end else begin
      bus_rvalid <= 0; bus_wack <= 0;
      if (bus_req && !bus_rvalid && !bus_wack) begin
        if (cnt == lat) begin
          cnt <= 0;
          acc <= acc + 1;
          if (bus_we) begin
            mem[bidx][bus_addr] <= bus_wdata;
            bus_wack <= 1;
          end else begin
            bus_rdata  <= mem[bidx][bus_addr];
            bus_rvalid <= 1;
          end
        end else cnt <= cnt + 1;
      end
    end
  end

  function automatic logic [31:0] mk(logic [3:0] op, logic [1:0] sel, logic [7:0] a,
                                     logic [7:0] lit, logic [4:0] lo, logic [4:0] hi);
    return {op, hi, lo, lit, sel, a};
  endfunction

  function automatic logic [31:0] exp_wr(logic [31:0] old, int lo, int hi, logic [7:0] lit);
    logic [31:0] r = old;
    for (int i = lo; i <= hi; i++) r[i] = (i - lo < 8) ? lit[i-lo] : 1'b0;
    return r;
  endfunction

  function automatic logic [15:0] exp_rd(logic [31:0] old, int lo, int hi);
    logic [15:0] r = '0;
    for (int i = lo; i <= hi; i++) if (i - lo < 16) r[i-lo] = old[i];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(logic [1:0] b, logic [7:0] a, logic [31:0] d);
    @(negedge clk); pl_en = 1; pl_bank = b; pl_addr = a; pl_data = d;
    @(negedge clk); pl_en = 0;
  endtask

  task automatic run(logic [31:0] w, int maxc, output logic gd, output logic ge,
                     output logic gw, output logic [15:0] gr);
    gd = 0; ge = 0; gw = 0; gr = '0;
    @(negedge clk); insn = w; start = 1;
    @(negedge clk); start = 0;
    for (int n = 0; n < maxc && !gd; n++) begin
      if (done) begin gd = 1; ge = err; gw = r0_we; gr = r0_data; end
      else @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic gd, ge, gw;
    logic [15:0] gr;
    int a0;
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {28'd0, done, err, bus_req, r0_we}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R11 after reset", {28'd0, done, err, bus_req, r0_we}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] op = VEC[v][63:60];
      logic [1:0] sel = VEC[v][59:58];
      logic [7:0] ad = VEC[v][57:50];
      logic [7:0] lit = VEC[v][49:42];
      logic [4:0] lo = VEC[v][41:37];
      logic [4:0] hi = VEC[v][36:32];
      logic [31:0] ini = VEC[v][31:0];
      lat = v % 3;
      preload(sel, ad, ini);
      a0 = acc;
      run(mk(op, sel, ad, lit, lo, hi), 40, gd, ge, gw, gr);
      check("R6 done seen", {31'd0, gd}, 32'd1);
      check("R7 no err on legal", {31'd0, ge}, 32'd0);
      if (op == 4'd1) begin
        check("R3 field write R1 R2", mem[sel][ad], exp_wr(ini, lo, hi, lit));
        check("R5 read then write", acc - a0, 2);
        check("R4 no r0_we on write", {31'd0, gw}, 32'd0);
      end else begin
        check("R4 read value", {16'd0, gr}, {16'd0, exp_rd(ini, lo, hi)});
        check("R4 r0_we", {31'd0, gw}, 32'd1);
        check("R4 target unchanged", mem[sel][ad], ini);
        check("R5 single read", acc - a0, 1);
      end
      @(negedge clk);
      check("R6 done one cycle", {31'd0, done}, 32'd0);
    end

    lat = 0;
    a0 = acc;
    run(mk(4'd1, 2'd3, 8'h10, 8'h55, 5'd0, 5'd7), 1, gd, ge, gw, gr);
    check("R7 bad bank done+err", {30'd0, gd, ge}, 32'd3);
    check("R7 no bus access", acc - a0, 0);

    preload(2'd0, 8'h44, 32'h0F0F_0F0F);
    a0 = acc;
    run(mk(4'd1, 2'd0, 8'h44, 8'h55, 5'd9, 5'd3), 1, gd, ge, gw, gr);
    check("R8 inverted done+err", {30'd0, gd, ge}, 32'd3);
    check("R8 no bus access", acc - a0, 0);
    check("R8 target unchanged", mem[0][8'h44], 32'h0F0F_0F0F);
    run(mk(4'd2, 2'd0, 8'h44, 8'h00, 5'd9, 5'd3), 1, gd, ge, gw, gr);
    check("R8 read inverted no r0_we", {29'd0, gd, ge, gw}, 32'd6);

    a0 = acc;
    run(mk(4'd0, 2'd0, 8'h44, 8'hAA, 5'd0, 5'd7), 20, gd, ge, gw, gr);
    check("R9 opcode 0 no done", {31'd0, gd}, 32'd0);
    run(mk(4'd5, 2'd0, 8'h44, 8'hAA, 5'd0, 5'd7), 20, gd, ge, gw, gr);
    check("R9 opcode 5 no done", {31'd0, gd}, 32'd0);
    check("R9 no bus access", acc - a0, 0);
    check("R9 target unchanged", mem[0][8'h44], 32'h0F0F_0F0F);

    lat = 2;
    preload(2'd1, 8'h60, 32'h0000_0000);
    preload(2'd1, 8'h61, 32'h0000_0000);
    @(negedge clk); insn = mk(4'd1, 2'd1, 8'h60, 8'hFF, 5'd0, 5'd7); start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); insn = mk(4'd1, 2'd1, 8'h61, 8'hFF, 5'd0, 5'd7); start = 1;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    check("R10 first write done", mem[1][8'h60], 32'h0000_00FF);
    check("R10 second start ignored", mem[1][8'h61], 32'h0000_0000);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule